// File: doc/BRIEF.md
# Game Controller Port Bus Interface

This block connects a byte-wide CPU bus to two serial game-controller ports. A write to the control address sets the shared strobe line that makes every attached controller capture its buttons. A read of a port's address returns that port's current serial bit in data bit 0 and makes that port's clock line active for as long as the read lasts. The host latches the controller's data line when the clock falls. The controller moves to its next bit when the clock rises again.

The port clocks come from a decode of the sampled read strobe and address. The decode is registered once on the system clock. If the address seen by the bus changes for a single cycle in the middle of a read, for example because a DMA fetch takes the bus, the decode briefly drops. The port clock then rises and falls again. The controller advances an extra step, and the button under the cursor is lost. A test input, `dma_glitch`, replaces the sampled address with a DMA address for the cycles in which it is high, so this failure can be reproduced on purpose.

Top module: `ctrlport_bus_if`

## Requirements
- R1: During and right after reset, both port clocks are high, the strobe line is low and `bus_rdata` is zero.
- R2: A bus write (`bus_en`=1, `bus_rd`=0) to address 0x4016 sets `pad_strobe` to `bus_wdata[0]` one clock later. The other data bits have no effect. Writes to any other address leave the strobe unchanged.
- R3: Port clock `pad_clk_n[p]` is low in the cycle after a sampled read of address 0x4016+p that has no glitch, and high otherwise. Port 0 is 0x4016 and port 1 is 0x4017. Reads of other addresses and all writes keep both clocks high.
- R4: When a port clock falls, the level of that port's `pad_data` bit in the cycle before is latched. `bus_rdata[0]` carries the latched value and `bus_rdata[7:1]` is zero.
- R5: While a port clock stays low over a multi-cycle read, `bus_rdata` does not change.
- R6: With a controller that shifts out bit 0 first, in the order A, B, Select, Start, Up, Down, Left, Right, and shifts in 1s, eight reads after a strobe pulse return button bits 0 to 7 in turn. Later reads return 1. Each read advances the controller by exactly one bit, whatever the read's length.
- R7: Reading one port never clocks the other port. After a full read-out of port 0, port 1 still starts at its bit 0.
- R8: A glitch cycle inside a read drives the clock high for one cycle and then low again. The read returns the next button bit, and exactly one bit is dropped from the sequence.
- R9: `dma_glitch` asserted while no port read is in progress has no effect on the port clocks or on the bit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| dma_glitch | input | 1 | Test: replace the sampled address with the DMA address this cycle |
| pad_data | input | 2 | Serial data from controller ports 0 and 1 |
| bus_rdata | output | 8 | Read data; bit 0 is the latched serial bit |
| pad_strobe | output | 1 | Shared controller strobe |
| pad_clk_n | output | 2 | Active-low port clocks, registered |

## Verification
The hardest case to reach is the lost bit. It needs a read held for several cycles, a glitch cycle placed strictly inside it, and a controller model whose shift follows the real rising edges of the port clock. The stimulus stretches a chosen read to three cycles and raises `dma_glitch` in the middle cycle. It sweeps the position of that read over every button index on both ports. Expected values come from shifting the pressed-button pattern by one position from that index onward.

// File: rtl/ctrlport_pkg.sv
package ctrlport_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_PORTS = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR_DEF = 16'h4016;
    localparam logic [ADDR_W-1:0] PORT_BASE_DEF = 16'h4016;
    localparam logic [ADDR_W-1:0] DMA_ADDR_DEF  = 16'hC000;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_WRITE,
        ACC_READ
    } acc_kind_t;

    typedef struct packed {
        logic              en;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic acc_kind_t acc_kind(bus_req_t r);
        if (!r.en) return ACC_IDLE;
        return r.rd ? ACC_READ : ACC_WRITE;
    endfunction

    function automatic logic is_read_of(bus_req_t r, logic [ADDR_W-1:0] a);
        return (acc_kind(r) == ACC_READ) && (r.addr == a);
    endfunction

    function automatic logic is_write_of(bus_req_t r, logic [ADDR_W-1:0] a);
        return (acc_kind(r) == ACC_WRITE) && (r.addr == a);
    endfunction

endpackage

// File: rtl/ctrlport_clkgen.sv
module ctrlport_clkgen
    import ctrlport_pkg::*;
#(
    parameter int                NPORTS    = NUM_PORTS,
    parameter logic [ADDR_W-1:0] PORT_BASE = PORT_BASE_DEF,
    parameter logic [ADDR_W-1:0] DMA_ADDR  = DMA_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              glitch,
    output logic [NPORTS-1:0] clk_n_q,
    output logic [NPORTS-1:0] fall
);

    bus_req_t          eff;
    logic [NPORTS-1:0] clk_n_d;

    // The address the decode really sees: a DMA fetch can replace it.
    always_comb begin
        eff = req;
        if (glitch) eff.addr = DMA_ADDR;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] MY_ADDR = PORT_BASE + ADDR_W'(p);

        assign clk_n_d[p] = !is_read_of(eff, MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst) clk_n_q[p] <= 1'b1;
            else     clk_n_q[p] <= clk_n_d[p];
        end

        assign fall[p] = clk_n_q[p] & ~clk_n_d[p];
    end

    // R8
    glitch_releases_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (glitch && acc_kind(req) == ACC_READ) |=> (&clk_n_q));

    // R3
    one_port_clocked_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~clk_n_q) <= 1);

endmodule

// File: rtl/ctrlport_strobe_reg.sv
module ctrlport_strobe_reg
    import ctrlport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = CTRL_ADDR_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     strobe_q
);

    always_ff @(posedge clk) begin
        if (rst)                           strobe_q <= 1'b0;
        else if (is_write_of(req, CTRL_ADDR)) strobe_q <= req.wdata[0];
    end

    // R2
    strobe_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req.en && !req.rd && req.addr == CTRL_ADDR) |=> (strobe_q == $past(req.wdata[0])));

    // R2
    strobe_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !(req.en && !req.rd && req.addr == CTRL_ADDR) |=> $stable(strobe_q));

endmodule

// File: rtl/ctrlport_rx_bit.sv
module ctrlport_rx_bit (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic din,
    output logic bit_q
);

    always_ff @(posedge clk) begin
        if (rst)       bit_q <= 1'b0;
        else if (fall) bit_q <= din;
    end

    // R4
    latch_only_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(fall) |-> $stable(bit_q));

endmodule

// File: rtl/ctrlport_bus_if.sv
module ctrlport_bus_if
    import ctrlport_pkg::*;
#(
    parameter int                NPORTS    = NUM_PORTS,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = CTRL_ADDR_DEF,
    parameter logic [ADDR_W-1:0] PORT_BASE = PORT_BASE_DEF,
    parameter logic [ADDR_W-1:0] DMA_ADDR  = DMA_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dma_glitch,
    input  logic [NPORTS-1:0] pad_data,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pad_strobe,
    output logic [NPORTS-1:0] pad_clk_n
);

    localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    bus_req_t          req;
    logic [NPORTS-1:0] fall;
    logic [NPORTS-1:0] bit_q;
    logic [PSEL_W-1:0] rd_port_q;

    assign req = '{en: bus_en, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    ctrlport_strobe_reg #(.CTRL_ADDR(CTRL_ADDR)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .strobe_q (pad_strobe)
    );

    ctrlport_clkgen #(
        .NPORTS    (NPORTS),
        .PORT_BASE (PORT_BASE),
        .DMA_ADDR  (DMA_ADDR)
    ) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .glitch  (dma_glitch),
        .clk_n_q (pad_clk_n),
        .fall    (fall)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_rx
        ctrlport_rx_bit u_rx (
            .clk   (clk),
            .rst   (rst),
            .fall  (fall[p]),
            .din   (pad_data[p]),
            .bit_q (bit_q[p])
        );
    end

    // Remember which port was read last so the bus returns its bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_port_q <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                if (fall[p]) rd_port_q <= PSEL_W'(p);
            end
        end
    end

    always_comb begin
        bus_rdata    = '0;
        bus_rdata[0] = bit_q[rd_port_q];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        // R3
        port_clk_decode_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (!pad_clk_n[p] == $past(bus_en && bus_rd && !dma_glitch &&
                                                  bus_addr == PORT_BASE + ADDR_W'(p))));

        // R4
        rdata_captures_pad_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(pad_clk_n[p]) |-> (bus_rdata[0] == $past(pad_data[p])));

        // R5
        rdata_held_in_read_chk: assert property (@(posedge clk) disable iff (rst)
            (!pad_clk_n[p] && $past(!pad_clk_n[p])) |-> $stable(bus_rdata));
    end

endmodule

// File: tb/ctrlport_bus_if_tb_top.sv
module ctrlport_bus_if_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en, bus_rd, dma_glitch;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [1:0]  pad_data;
    logic [7:0]  bus_rdata;
    logic        pad_strobe;
    logic [1:0]  pad_clk_n;

    logic [7:0]  btn0, btn1, sr0, sr1;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctrlport_bus_if dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_en     (bus_en),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .dma_glitch (dma_glitch),
        .pad_data   (pad_data),
        .bus_rdata  (bus_rdata),
        .pad_strobe (pad_strobe),
        .pad_clk_n  (pad_clk_n)
    );

    // Controller models: load while strobe high, shift on rising port clock.
    always @(posedge pad_clk_n[0] or posedge pad_strobe)
        if (pad_strobe) sr0 <= btn0; else sr0 <= {1'b1, sr0[7:1]};
    always @(posedge pad_clk_n[1] or posedge pad_strobe)
        if (pad_strobe) sr1 <= btn1; else sr1 <= {1'b1, sr1[7:1]};
    assign pad_data = {sr1[0], sr0[0]};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic do_read(input int port, input int ncyc, input int gl,
                           output logic [7:0] val);
        logic [7:0] first;
        first = '0;
        @(negedge clk);
        bus_en = 1'b1; bus_rd = 1'b1; bus_addr = 16'h4016 + 16'(port);
        for (int c = 0; c < ncyc; c++) begin
            dma_glitch = (c == gl);
            @(negedge clk);
            val = bus_rdata;
            if (c == 0) first = val;
            chk("R3 read clk", 32'(pad_clk_n[port]), (c == gl) ? 1 : 0);
            chk("R7 other clk", 32'(pad_clk_n[1 - port]), 1);
        end
        bus_en = 1'b0; dma_glitch = 1'b0;
        chk("R4 upper bits", 32'(val[7:1]), 0);
        if (gl < 0 && ncyc > 1) chk("R5 stable", 32'(val), 32'(first));
    endtask

    task automatic strobe_pulse;
        bus_write(16'h4016, 8'h01);
        bus_write(16'h4016, 8'h00);
    endtask

    function automatic logic exp_bit(logic [7:0] pat, int idx);
        return (idx < 8) ? pat[idx] : 1'b1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pat;
        rst = 1'b1; bus_en = 1'b0; bus_rd = 1'b0; dma_glitch = 1'b0;
        bus_addr = '0; bus_wdata = '0; btn0 = '0; btn1 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 clocks", 32'(pad_clk_n), 32'h3);
        chk("R1 strobe", 32'(pad_strobe), 0);
        chk("R1 rdata", 32'(bus_rdata), 0);

        // R2: strobe write decode
        bus_write(16'h4016, 8'hFF); chk("R2 set", 32'(pad_strobe), 1);
        bus_write(16'h4016, 8'hFE); chk("R2 bit0 only", 32'(pad_strobe), 0);
        bus_write(16'h4016, 8'h01); chk("R2 set again", 32'(pad_strobe), 1);
        bus_write(16'h4017, 8'h00); chk("R2 other addr", 32'(pad_strobe), 1);
        bus_write(16'h2000, 8'h00); chk("R2 far addr", 32'(pad_strobe), 1);
        bus_write(16'h4016, 8'h00); chk("R2 clear", 32'(pad_strobe), 0);

        // R3: reads elsewhere and writes never clock a port
        @(negedge clk);
        bus_en = 1'b1; bus_rd = 1'b1; bus_addr = 16'h4015;
        @(negedge clk);
        chk("R3 foreign read", 32'(pad_clk_n), 32'h3);
        bus_rd = 1'b0; bus_addr = 16'h4017;
        @(negedge clk);
        chk("R3 write port addr", 32'(pad_clk_n), 32'h3);
        bus_en = 1'b0;

        // R6, R7: pattern sweep, both ports, reads of 1..3 cycles
        for (int k = 0; k < 24; k++) begin
            pat  = 8'(k * 29) ^ 8'h3C;
            btn0 = pat;
            btn1 = ~pat ^ 8'(k);
            strobe_pulse();
            for (int j = 0; j < 10; j++) begin
                do_read(0, (k % 3) + 1, -1, v);
                chk("R6 port0 bit", 32'(v[0]), 32'(exp_bit(btn0, j)));
            end
            for (int j = 0; j < 10; j++) begin
                do_read(1, ((k + 1) % 3) + 1, -1, v);
                chk("R7 port1 bit", 32'(v[0]), 32'(exp_bit(btn1, j)));
            end
        end

        // R8: glitch inside read g drops exactly one bit
        for (int port = 0; port < 2; port++) begin
            for (int g = 0; g < 8; g++) begin
                pat  = 8'hA5 ^ 8'(g * 19) ^ 8'(port * 77);
                btn0 = pat; btn1 = ~pat;
                strobe_pulse();
                for (int j = 0; j < 9; j++) begin
                    if (j == g) do_read(port, 3, 1, v);
                    else        do_read(port, 1, -1, v);
                    chk("R8 dropped bit", 32'(v[0]),
                        32'(exp_bit(port == 0 ? btn0 : btn1, (j < g) ? j : j + 1)));
                end
            end
        end

        // R9: glitch with no read in progress
        btn0 = 8'h69; btn1 = 8'h96;
        strobe_pulse();
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            dma_glitch = 1'b1;
            @(negedge clk);
            dma_glitch = 1'b0;
            chk("R9 clocks idle", 32'(pad_clk_n), 32'h3);
            do_read(j % 2, 1, -1, v);
            chk("R9 sequence", 32'(v[0]), 32'(exp_bit((j % 2) == 0 ? btn0 : btn1, j / 2)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule